// File: doc/BRIEF.md
# Sequential Signed Divider with Quotient-Extension Register

This block carries out the two divide operations of an older integer unit in which a separate 32-bit extension register (called MQ here) supplies extra dividend bits and receives the remainder. In the long form, operand A is the upper word and MQ the lower word of a signed 64-bit dividend. In the short form, only the signed 32-bit operand A is divided. Both forms divide by the signed 32-bit operand B. The quotient goes to the destination register and the remainder goes back to MQ. The remainder always has the sign of the dividend, so that remainder + divisor × quotient = dividend.

The surrounding pipeline raises `start` for one cycle with the operands, the form select and the overflow-enable and record bits. The block captures all of these on that edge. It works on magnitudes and produces one quotient bit per cycle. It restores the signs in a final cycle and then pulses `done` with the results. While the block is busy, `start` has no effect. A zero divisor skips the iteration and returns fixed values.

Top module: `mq_divider`

## Requirements
- R1: With `long_form`=1, `quotient` is the low 32 bits of the signed quotient of {src_a, mq_in} divided by src_b, truncated toward zero.
- R2: With `long_form`=0, `quotient` is the low 32 bits of the signed quotient of src_a divided by src_b, truncated toward zero.
- R3: `remainder` has the sign of the dividend (or is zero), its magnitude is below that of the divisor, and remainder + divisor × quotient equals the dividend.
- R4: When the overflow-enable bit was set, `ov_set` and `so_set` are both 1 exactly when the true signed quotient lies outside the signed 32-bit range. When it was clear, both are 0.
- R5: When the record bit was set, `cr_field` is {LT, GT, EQ} (bit 2 LT, bit 1 GT, bit 0 EQ) and shows the signed remainder compared with zero, with exactly one bit high. When the record bit was clear, `cr_field` is 3'b000.
- R6: `done` is high for exactly one cycle. Counting the edge that accepts `start` as the first edge, `done` rises after edge 66 for the long form and after edge 34 for the short form (64 or 32 iterations).
- R7: A zero divisor finishes after the second edge. It gives `quotient` = 32'hFFFFFFFF and `remainder` equal to the low dividend word (mq_in for the long form, src_a for the short form), and it counts as overflow under R4.
- R8: `start` is ignored while `busy` is high. Operands, form and flag bits are taken only on the accepting edge, so later changes to these inputs do not affect the result.
- R9: After reset, `busy`, `done`, `quotient`, `remainder`, `ov_set`, `so_set` and `cr_field` are all zero.
- R10: `busy` is high from the edge after acceptance until `done` rises, and it is low in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| long_form | input | 1 | 1: 64-bit dividend {src_a, mq_in}; 0: 32-bit dividend src_a |
| oe | input | 1 | Overflow-enable bit of the operation |
| rc | input | 1 | Record bit of the operation |
| src_a | input | 32 | Operand A (dividend, or its upper word) |
| src_b | input | 32 | Divisor |
| mq_in | input | 32 | Current extension register value (low dividend word) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 32 | Quotient for the destination register |
| remainder | output | 32 | Remainder for the extension register |
| ov_set | output | 1 | Overflow flag update |
| so_set | output | 1 | Summary-overflow flag update |
| cr_field | output | 3 | {LT, GT, EQ} from the remainder |

## Verification
The divider is exercised with all four sign combinations of dividend and divisor in both forms, so that a wrong sign on the quotient or remainder shows up. Long-form dividends whose upper word is a sign extension give fitting quotients. Random upper words give overflowing ones, which separates the overflow rule from the plain quotient path. Directed cases cover the most negative dividend divided by minus one, a zero dividend for the EQ bit, and a zero divisor in each form. During every run the bench scrambles the operand inputs and pulses `start` again, so a design that re-captures operands or restarts shows a wrong result or a wrong latency.

// File: rtl/mqdiv_pkg.sv
package mqdiv_pkg;

    // Sequencer states of the divider
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mqdiv_state_e;

    // Bit positions inside the condition field output
    localparam int CR_LT = 2;
    localparam int CR_GT = 1;
    localparam int CR_EQ = 0;

endpackage

// File: rtl/mqdiv_operand_prep.sv
// Splits the signed operands into sign flags and unsigned magnitudes.
module mqdiv_operand_prep #(
    parameter int DW = 32,
    localparam int DDW = 2 * DW
) (
    input  logic           long_form,
    input  logic [DW-1:0]  src_a,
    input  logic [DW-1:0]  src_b,
    input  logic [DW-1:0]  mq_in,
    output logic [DDW-1:0] dvd_load,
    output logic [DW-1:0]  dvs_mag,
    output logic           dvd_neg,
    output logic           dvs_neg,
    output logic [DW-1:0]  low_word
);
    logic [DDW-1:0] full_dvd;
    logic [DW-1:0]  short_mag;

    always_comb begin
        full_dvd  = {src_a, mq_in};
        dvd_neg   = src_a[DW-1];
        dvs_neg   = src_b[DW-1];
        short_mag = dvd_neg ? ({DW{1'b0}} - src_a) : src_a;
        if (long_form) begin
            dvd_load = dvd_neg ? ({DDW{1'b0}} - full_dvd) : full_dvd;
            low_word = mq_in;
        end else begin
            // short magnitude sits in the upper half so the same shift path serves both forms
            dvd_load = {short_mag, {DW{1'b0}}};
            low_word = src_a;
        end
        dvs_mag = dvs_neg ? ({DW{1'b0}} - src_b) : src_b;
    end
endmodule

// File: rtl/mqdiv_step.sv
// One restoring-division iteration: shift in a dividend bit, trial subtract.
module mqdiv_step #(
    parameter int DW = 32,
    localparam int DDW = 2 * DW
) (
    input  logic [DW-1:0]  rem_i,
    input  logic [DDW-1:0] dq_i,
    input  logic [DW-1:0]  dvs,
    output logic [DW-1:0]  rem_o,
    output logic [DDW-1:0] dq_o
);
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    always_comb begin
        trial = {rem_i, dq_i[DDW-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
        rem_o = fits ? diff[DW-1:0] : trial[DW-1:0];
        dq_o  = {dq_i[DDW-2:0], fits};
    end
endmodule

// File: rtl/mqdiv_result_fix.sv
// Restores signs, detects quotient overflow and builds the condition field.
module mqdiv_result_fix #(
    parameter int DW = 32,
    localparam int DDW = 2 * DW
) (
    input  logic [DDW-1:0] q_mag,
    input  logic [DW-1:0]  r_mag,
    input  logic           dvd_neg,
    input  logic           dvs_neg,
    input  logic           div_zero,
    input  logic [DW-1:0]  low_word,
    input  logic           oe,
    input  logic           rc,
    output logic [DW-1:0]  quo,
    output logic [DW-1:0]  rmd,
    output logic           ovf_flag,
    output logic [2:0]     cr
);
    logic [DDW-1:0] q_signed;
    logic [DDW-DW:0] top_bits;
    logic           out_of_range;

    always_comb begin
        q_signed     = (dvd_neg ^ dvs_neg) ? ({DDW{1'b0}} - q_mag) : q_mag;
        top_bits     = q_signed[DDW-1:DW-1];
        out_of_range = !((&top_bits) || !(|top_bits));
        if (div_zero) begin
            quo = {DW{1'b1}};
            rmd = low_word;
        end else begin
            quo = q_signed[DW-1:0];
            rmd = dvd_neg ? ({DW{1'b0}} - r_mag) : r_mag;
        end
        ovf_flag = oe && (div_zero || out_of_range);
        cr = 3'b000;
        if (rc) begin
            cr[mqdiv_pkg::CR_LT] = rmd[DW-1];
            cr[mqdiv_pkg::CR_EQ] = (rmd == {DW{1'b0}});
            cr[mqdiv_pkg::CR_GT] = !rmd[DW-1] && (rmd != {DW{1'b0}});
        end
    end
endmodule

// File: rtl/mq_divider.sv
module mq_divider #(
    parameter int DW = 32,
    localparam int DDW  = 2 * DW,
    localparam int CNTW = $clog2(DDW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          long_form,
    input  logic          oe,
    input  logic          rc,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] mq_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder,
    output logic          ov_set,
    output logic          so_set,
    output logic [2:0]    cr_field
);
    import mqdiv_pkg::*;

    typedef struct packed {
        mqdiv_state_e   st;
        logic [CNTW-1:0] cnt;
        logic [DW-1:0]  rem;
        logic [DDW-1:0] dq;
        logic [DW-1:0]  dvs;
        logic           dvd_neg;
        logic           dvs_neg;
        logic           div_zero;
        logic [DW-1:0]  low_word;
        logic           oe;
        logic           rc;
        logic [DW-1:0]  quo;
        logic [DW-1:0]  rmd;
        logic           ovf;
        logic [2:0]     cr;
        logic           done;
    } regs_t;

    regs_t state_q, state_d;

    logic [DDW-1:0] prep_dq;
    logic [DW-1:0]  prep_dvs;
    logic           prep_dvd_neg;
    logic           prep_dvs_neg;
    logic [DW-1:0]  prep_low;
    logic [DW-1:0]  step_rem;
    logic [DDW-1:0] step_dq;
    logic [DW-1:0]  fix_quo;
    logic [DW-1:0]  fix_rmd;
    logic           fix_ovf;
    logic [2:0]     fix_cr;

    mqdiv_operand_prep #(.DW(DW)) i_prep (
        .long_form (long_form),
        .src_a     (src_a),
        .src_b     (src_b),
        .mq_in     (mq_in),
        .dvd_load  (prep_dq),
        .dvs_mag   (prep_dvs),
        .dvd_neg   (prep_dvd_neg),
        .dvs_neg   (prep_dvs_neg),
        .low_word  (prep_low)
    );

    mqdiv_step #(.DW(DW)) i_step (
        .rem_i (state_q.rem),
        .dq_i  (state_q.dq),
        .dvs   (state_q.dvs),
        .rem_o (step_rem),
        .dq_o  (step_dq)
    );

    mqdiv_result_fix #(.DW(DW)) i_fix (
        .q_mag    (state_q.dq),
        .r_mag    (state_q.rem),
        .dvd_neg  (state_q.dvd_neg),
        .dvs_neg  (state_q.dvs_neg),
        .div_zero (state_q.div_zero),
        .low_word (state_q.low_word),
        .oe       (state_q.oe),
        .rc       (state_q.rc),
        .quo      (fix_quo),
        .rmd      (fix_rmd),
        .ovf_flag (fix_ovf),
        .cr       (fix_cr)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (start) begin
                    state_d.div_zero = (src_b == {DW{1'b0}});
                    state_d.st       = (src_b == {DW{1'b0}}) ? ST_FIN : ST_RUN;
                    state_d.cnt      = long_form ? CNTW'(DDW - 1) : CNTW'(DW - 1);
                    state_d.rem      = {DW{1'b0}};
                    state_d.dq       = prep_dq;
                    state_d.dvs      = prep_dvs;
                    state_d.dvd_neg  = prep_dvd_neg;
                    state_d.dvs_neg  = prep_dvs_neg;
                    state_d.low_word = prep_low;
                    state_d.oe       = oe;
                    state_d.rc       = rc;
                end
            end
            ST_RUN: begin
                state_d.rem = step_rem;
                state_d.dq  = step_dq;
                state_d.cnt = state_q.cnt - 1'b1;
                if (state_q.cnt == {CNTW{1'b0}}) begin
                    state_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                state_d.quo  = fix_quo;
                state_d.rmd  = fix_rmd;
                state_d.ovf  = fix_ovf;
                state_d.cr   = fix_cr;
                state_d.done = 1'b1;
                state_d.st   = ST_IDLE;
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy      = (state_q.st != ST_IDLE);
    assign done      = state_q.done;
    assign quotient  = state_q.quo;
    assign remainder = state_q.rmd;
    assign ov_set    = state_q.ovf;
    assign so_set    = state_q.ovf;
    assign cr_field  = state_q.cr;

endmodule

// File: rtl/mqdiv_checker.sv
module mqdiv_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] quotient,
    input logic [DW-1:0] remainder,
    input logic          ov_set,
    input logic          so_set,
    input logic [2:0]    cr_field
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R10
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R8
    AST_CR_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cr_field)); // R5
    AST_SO_WITH_OV: assert property (@(posedge clk) disable iff (!rst_n) so_set == ov_set); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(quotient) && $stable(remainder))); // R8
endmodule

bind mq_divider mqdiv_checker #(.DW(DW)) i_mqdiv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .ov_set    (ov_set),
    .so_set    (so_set),
    .cr_field  (cr_field)
);

// File: tb/test_mq_divider.sv
`timescale 1ns/1ps
module test_mq_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        long_form = 1'b0;
    logic        oe = 1'b0;
    logic        rc = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] mq_in = '0;
    logic        busy, done, ov_set, so_set;
    logic [31:0] quotient, remainder;
    logic [2:0]  cr_field;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mq_divider i_mq_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .long_form(long_form),
        .oe(oe), .rc(rc), .src_a(src_a), .src_b(src_b), .mq_in(mq_in),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .ov_set(ov_set), .so_set(so_set), .cr_field(cr_field)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Reference model from the requirements
    function automatic void model(input logic lf, input logic [31:0] a, b, m,
                                  output logic [31:0] q, r, output logic ovf);
        logic [63:0] dvd, magd, magb, qm, rm, q64;
        logic        nd;
        dvd  = lf ? {a, m} : {{32{a[31]}}, a};
        nd   = dvd[63];
        magd = nd ? (64'd0 - dvd) : dvd;
        magb = b[31] ? (64'd0 - {{32{1'b1}}, b}) : {32'd0, b};
        if (b == 32'd0) begin
            q = 32'hFFFF_FFFF;
            r = lf ? m : a;
            ovf = 1'b1;
        end else begin
            qm  = magd / magb;
            rm  = magd % magb;
            q64 = (nd ^ b[31]) ? (64'd0 - qm) : qm;
            q   = q64[31:0];
            r   = nd ? (32'd0 - rm[31:0]) : rm[31:0];
            ovf = (q64[63:31] != '0) && (q64[63:31] != '1);
        end
    endfunction

    task automatic run_op(input logic lf, input logic oe_i, input logic rc_i,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] m);
        logic [31:0] eq, er;
        logic        eovf;
        logic [2:0]  ecr;
        int          cyc;
        int          elat;
        model(lf, a, b, m, eq, er, eovf);
        ecr = 3'b000;
        if (rc_i) ecr = er[31] ? 3'b100 : ((er == 0) ? 3'b001 : 3'b010);
        elat = (b == 0) ? 2 : (lf ? 66 : 34);
        @(negedge clk);
        start = 1'b1; long_form = lf; oe = oe_i; rc = rc_i;
        src_a = a; src_b = b; mq_in = m;
        @(posedge clk);
        #1;
        start = 1'b0;
        // scramble inputs after acceptance: R8
        src_a = $urandom; src_b = $urandom; mq_in = $urandom;
        long_form = ~lf; oe = ~oe_i; rc = ~rc_i;
        cyc = 0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2 && b != 0) chk("R10 busy during run", {63'd0, busy}, 64'd1);
            if (cyc == 3) start = 1'b1;   // R8: ignored while busy
            if (cyc == 4) start = 1'b0;
            if (done) break;
        end
        start = 1'b0;
        chk("R6/R8 latency", 64'(cyc), 64'(elat));
        chk("R10 busy low at done", {63'd0, busy}, 64'd0);
        if (b == 0) begin
            chk("R7 zero-divisor quotient", {32'd0, quotient}, {32'd0, eq});
            chk("R7 zero-divisor remainder", {32'd0, remainder}, {32'd0, er});
        end else begin
            chk(lf ? "R1 long quotient" : "R2 short quotient", {32'd0, quotient}, {32'd0, eq});
            chk("R3 remainder", {32'd0, remainder}, {32'd0, er});
        end
        chk("R4 ov_set", {63'd0, ov_set}, {63'd0, oe_i & eovf});
        chk("R4 so_set", {63'd0, so_set}, {63'd0, oe_i & eovf});
        chk("R5 cr_field", {61'd0, cr_field}, {61'd0, ecr});
        @(negedge clk);
        chk("R6 done single cycle", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b, m;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", {63'd0, busy}, 64'd0);
        chk("R9 done", {63'd0, done}, 64'd0);
        chk("R9 quotient", {32'd0, quotient}, 64'd0);
        chk("R9 remainder", {32'd0, remainder}, 64'd0);
        chk("R9 flags", {60'd0, ov_set, cr_field}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op(1'b0, 1'b1, 1'b1, 32'd7, 32'hFFFF_FFFE, 32'd0);          // 7 / -2
        run_op(1'b0, 1'b1, 1'b1, 32'hFFFF_FFF9, 32'd2, 32'd0);          // -7 / 2
        run_op(1'b0, 1'b1, 1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'd0);  // -7 / -2
        run_op(1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);  // short overflow
        run_op(1'b0, 1'b0, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);  // overflow, oe clear
        run_op(1'b0, 1'b1, 1'b1, 32'd0, 32'd5, 32'd0);                  // zero dividend: EQ
        run_op(1'b1, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);  // most negative long
        run_op(1'b1, 1'b1, 1'b0, 32'd0, 32'd10, 32'd123);               // long, rc clear
        run_op(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1000, 32'h8000_0001); // long, negative
        run_op(1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'd3, 32'h9ABC_DEF0);  // long overflow
        run_op(1'b1, 1'b1, 1'b1, 32'd5, 32'd0, 32'hCAFE_F00D);          // R7 long zero divisor
        run_op(1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'd0, 32'd9);          // R7 short zero divisor
        run_op(1'b0, 1'b0, 1'b0, 32'd100, 32'd0, 32'd9);                // R7 with oe clear

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            logic lf;
            lf = 1'($urandom % 2);
            b  = $urandom;
            if ($urandom % 4 == 0) b = $urandom % 16 + 1;
            if (b == 0) b = 32'd3;
            m  = $urandom;
            a  = $urandom;
            if (lf && ($urandom % 2 == 1)) a = ($urandom % 2 == 1) ? 32'hFFFF_FFFF : 32'd0;
            run_op(lf, 1'($urandom % 2), 1'($urandom % 2), a, b, m);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule